// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how long a slow clock cycle lasts by counting cycles of a fast reference clock. Software picks one of four slow sources and programs a window of N slow clock periods. The block then reports how many reference cycles those N periods took. The whole block runs on the reference clock. The selected slow clock is brought in through a flop synchronizer, and its rising edges are detected in the reference domain.

Two operating modes exist. In one-shot mode a rising edge on the start bit clears the ready flag, and the next synchronized slow edge opens a single window. When that window closes, the block sets ready and goes idle. In continuous mode the block re-arms after every window with no software action, and it refreshes the result each time. Continuous mode is selected out of reset, so a measurement is available soon after power-up without any programming. The reference count saturates at all ones and does not wrap, so a window that is too long reads as full scale.

Top module: `slow_clk_cal_counter`

## Requirements
- R1: After reset, ready is 0, result is 0 and continuous mode is selected. With no start pulse, the first result appears once one window has completed.
- R2: src_sel picks the measured slow input: 0 = internal 150 kHz oscillator (slow_rc150), 1 = 32.768 kHz crystal (slow_xtal), 2 = fast RC clock divided by 256 (slow_rcdiv), 3 = currently active slow clock mux output (slow_active).
- R3: result equals the number of reference cycles from the synchronized slow rising edge that opens a window to the edge that closes it, N edges later. For a slow clock with a period of exactly P reference cycles, result = N*P.
- R4: N is max_cycles captured when the window opens, and a max_cycles of 0 is treated as 1. A change to max_cycles during a window affects only later windows.
- R5: In one-shot mode, a rising edge of start clears ready in the next cycle and re-arms the block. After one window, ready goes to 1 and result then holds. Start held high, a source change and a max_cycles change have no effect until the next rising edge of start.
- R6: In continuous mode, the next window opens at the first slow edge after a window closes. result is refreshed and ready is set at the end of each window.
- R7: The reference count saturates at all ones (2^CNT_W-1) instead of wrapping, and a window that overflows reports all ones.
- R8: A cycle with cfg_we high loads cfg_cont into the mode bit (1 = continuous, 0 = one-shot). Setting continuous while idle starts measuring with no start pulse.
- R9: A slow input that is already high when reset is released does not produce a false opening edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_rc150 | input | 1 | Internal 150 kHz oscillator |
| slow_xtal | input | 1 | 32.768 kHz crystal clock |
| slow_rcdiv | input | 1 | Fast RC clock divided by 256 |
| slow_active | input | 1 | Active slow clock mux output |
| src_sel | input | 2 | Source select (see R2) |
| max_cycles | input | MAX_W | Window length in slow periods |
| start | input | 1 | One-shot start, rising-edge triggered |
| cfg_we | input | 1 | Mode bit write strobe |
| cfg_cont | input | 1 | Mode bit value: 1 continuous, 0 one-shot |
| ready | output | 1 | Measurement complete, result valid |
| result | output | CNT_W | Reference cycles counted in the window |

## Verification
The bench builds the block with CNT_W = 8 and MAX_W = 4, so the full range of the max_cycles field can be swept quickly. With an 8-bit count, a slow source whose period is 40 reference cycles overflows the counter within a window of only ten slow periods, which brings saturation within reach. Each slow input is driven with its own exact period (6, 10, 8 and 40 reference cycles), so every select code yields a distinct, predictable N*P result, and the zero-length window case is easy to tell apart.

// File: rtl/slow_cal_pkg.sv
package slow_cal_pkg;

    // Slow source select codes (R2)
    typedef enum logic [1:0] {
        SRC_RC150  = 2'd0,
        SRC_XTAL   = 2'd1,
        SRC_RCDIV  = 2'd2,
        SRC_ACTIVE = 2'd3
    } cal_src_e;

    localparam int unsigned NUM_SRC = 4;

    // Measurement controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } cal_state_e;

endpackage

// File: rtl/slow_src_mux.sv
module slow_src_mux
    import slow_cal_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_in,
    input  cal_src_e           sel,
    output logic               src_out
);

    always_comb begin
        src_out = src_in[sel];
    end

endmodule

// File: rtl/cal_edge_sync.sv
module cal_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    // Previous level resets high so a high input at release is not a rise
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/cal_window_ctrl.sv
module cal_window_ctrl
    import slow_cal_pkg::*;
#(
    parameter int unsigned CNT_W = 20,
    parameter int unsigned MAX_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_edge,
    input  logic             start,
    input  logic             cfg_we,
    input  logic             cfg_cont,
    input  logic [MAX_W-1:0] max_cycles,
    output logic             ready,
    output logic [CNT_W-1:0] result,
    output cal_state_e       state_o,
    output logic [CNT_W-1:0] ref_cnt_o
);

    cal_state_e       state;
    logic             start_q;
    logic             cont_q;
    logic [CNT_W-1:0] ref_cnt;
    logic [MAX_W-1:0] slow_cnt;
    logic [MAX_W-1:0] win_len;

    logic             start_rise;
    logic [CNT_W-1:0] ref_inc;
    logic [MAX_W-1:0] slow_nxt;
    logic [MAX_W-1:0] len_eff;

    always_comb begin
        start_rise = start & ~start_q;
        ref_inc    = (ref_cnt == '1) ? ref_cnt : ref_cnt + CNT_W'(1);
        slow_nxt   = slow_cnt + MAX_W'(1);
        len_eff    = (max_cycles == '0) ? MAX_W'(1) : max_cycles;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= 1'b0;
            cont_q   <= 1'b1;
            state    <= ST_ARM;
            ready    <= 1'b0;
            result   <= '0;
            ref_cnt  <= '0;
            slow_cnt <= '0;
            win_len  <= MAX_W'(1);
        end else begin
            start_q <= start;
            if (cfg_we) cont_q <= cfg_cont;

            if (start_rise) begin
                ready    <= 1'b0;
                ref_cnt  <= '0;
                slow_cnt <= '0;
                state    <= ST_ARM;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (cont_q) state <= ST_ARM;
                    end
                    ST_ARM: begin
                        if (slow_edge) begin
                            state    <= ST_COUNT;
                            ref_cnt  <= '0;
                            slow_cnt <= '0;
                            win_len  <= len_eff;
                        end
                    end
                    ST_COUNT: begin
                        ref_cnt <= ref_inc;
                        if (slow_edge) begin
                            if (slow_nxt == win_len) begin
                                result <= ref_inc;
                                ready  <= 1'b1;
                                state  <= cont_q ? ST_ARM : ST_IDLE;
                            end else begin
                                slow_cnt <= slow_nxt;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign state_o   = state;
    assign ref_cnt_o = ref_cnt;

endmodule

// File: rtl/slow_clk_cal_counter.sv
module slow_clk_cal_counter
    import slow_cal_pkg::*;
#(
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned MAX_W       = 15,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_rc150,
    input  logic             slow_xtal,
    input  logic             slow_rcdiv,
    input  logic             slow_active,
    input  logic [1:0]       src_sel,
    input  logic [MAX_W-1:0] max_cycles,
    input  logic             start,
    input  logic             cfg_we,
    input  logic             cfg_cont,
    output logic             ready,
    output logic [CNT_W-1:0] result
);

    logic [NUM_SRC-1:0] src_vec;
    logic               slow_sel;
    logic               dbg_edge;
    cal_state_e         dbg_state;
    logic [CNT_W-1:0]   dbg_ref_cnt;

    assign src_vec = {slow_active, slow_rcdiv, slow_xtal, slow_rc150};

    slow_src_mux i_mux (
        .src_in  (src_vec),
        .sel     (cal_src_e'(src_sel)),
        .src_out (slow_sel)
    );

    cal_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (slow_sel),
        .rise (dbg_edge)
    );

    cal_window_ctrl #(.CNT_W(CNT_W), .MAX_W(MAX_W)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .slow_edge  (dbg_edge),
        .start      (start),
        .cfg_we     (cfg_we),
        .cfg_cont   (cfg_cont),
        .max_cycles (max_cycles),
        .ready      (ready),
        .result     (result),
        .state_o    (dbg_state),
        .ref_cnt_o  (dbg_ref_cnt)
    );

endmodule

// File: rtl/slow_cal_checker.sv
module slow_cal_checker
    import slow_cal_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             ready,
    input logic [CNT_W-1:0] result,
    input logic [1:0]       st,
    input logic [CNT_W-1:0] ref_cnt,
    input logic             slow_edge
);

    assert_ready_low_after_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(start) |=> !ready);

    assert_result_moves_with_ready_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> ready);

    assert_idle_holds_result_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> $stable(result));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (ref_cnt == '1) |=> (ref_cnt == '1 || ref_cnt == '0));

    assert_single_cycle_edge_R9: assert property (@(posedge clk) disable iff (rst)
        slow_edge |=> !slow_edge);

endmodule

bind slow_clk_cal_counter slow_cal_checker #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ready     (ready),
    .result    (result),
    .st        (dbg_state),
    .ref_cnt   (dbg_ref_cnt),
    .slow_edge (dbg_edge)
);

// File: tb/test_slow_clk_cal_counter.sv
`timescale 1ns/1ps
module test_slow_clk_cal_counter;

    localparam int CNT_W = 8;
    localparam int MAX_W = 4;
    localparam int P_RC150 = 6, P_XTAL = 10, P_RCDIV = 8, P_ACT = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_rc150 = 1'b0, s_xtal = 1'b0, s_rcdiv = 1'b0, s_act = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [MAX_W-1:0] max_cycles = 4'd3;
    logic start = 1'b0, cfg_we = 1'b0, cfg_cont = 1'b0;
    logic ready;
    logic [CNT_W-1:0] result;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    initial forever begin repeat (P_RC150/2) @(negedge clk); s_rc150 = ~s_rc150; end
    initial forever begin repeat (P_XTAL/2)  @(negedge clk); s_xtal  = ~s_xtal;  end
    initial forever begin repeat (P_RCDIV/2) @(negedge clk); s_rcdiv = ~s_rcdiv; end
    initial forever begin repeat (P_ACT/2)   @(negedge clk); s_act   = ~s_act;   end

    slow_clk_cal_counter #(.CNT_W(CNT_W), .MAX_W(MAX_W)) i_slow_clk_cal_counter (
        .clk(clk), .rst(rst),
        .slow_rc150(s_rc150), .slow_xtal(s_xtal), .slow_rcdiv(s_rcdiv), .slow_active(s_act),
        .src_sel(src_sel), .max_cycles(max_cycles), .start(start),
        .cfg_we(cfg_we), .cfg_cont(cfg_cont), .ready(ready), .result(result)
    );

    function automatic int expect_val(input logic [1:0] s, input logic [3:0] m);
        int p, n, v;
        case (s)
            2'd0: p = P_RC150;
            2'd1: p = P_XTAL;
            2'd2: p = P_RCDIV;
            default: p = P_ACT;
        endcase
        n = (m == 0) ? 1 : int'(m);
        v = n * p;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ready(input string req);
        int n;
        n = 0;
        while (!ready && n < 2000) begin @(negedge clk); n++; end
        check(req, int'(ready), 1);
    endtask

    task automatic write_mode(input logic v);
        @(negedge clk); cfg_we = 1'b1; cfg_cont = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk);
    endtask

    // {src_sel, max_cycles}
    localparam logic [5:0] VEC [0:8] = '{
        {2'd0, 4'd1}, {2'd0, 4'd15}, {2'd1, 4'd3}, {2'd2, 4'd5}, {2'd3, 4'd3},
        {2'd3, 4'd10}, {2'd1, 4'd0}, {2'd2, 4'd15}, {2'd3, 4'd6}
    };

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 ready at reset", int'(ready), 0);
        check("R1 result at reset", int'(result), 0);
        rst = 1'b0;
        // R1/R6: continuous from reset, src 0, max 3
        wait_ready("R1 continuous ready without start");
        check("R1 continuous result", int'(result), expect_val(2'd0, 4'd3));

        write_mode(1'b0);
        // R2, R3, R4, R5, R7 via vector table in one-shot mode
        foreach (VEC[i]) begin
            @(negedge clk);
            src_sel = VEC[i][5:4];
            max_cycles = VEC[i][3:0];
            pulse_start();
            check("R5 ready cleared by start", int'(ready), 0);
            wait_ready("R5 ready after window");
            check($sformatf("R3 R2 vector %0d result", i), int'(result),
                  expect_val(VEC[i][5:4], VEC[i][3:0]));
        end

        // R7: overflow window did not wrap
        @(negedge clk); src_sel = 2'd3; max_cycles = 4'd12;
        pulse_start();
        wait_ready("R7 ready");
        check("R7 saturated result", int'(result), 255);

        // R5: start held high, source and length changes ignored while idle
        @(negedge clk); src_sel = 2'd0; max_cycles = 4'd2;
        repeat (800) @(negedge clk);
        check("R5 result held in one-shot", int'(result), 255);
        check("R5 ready held in one-shot", int'(ready), 1);

        // R4: max changed mid-window only affects later windows
        @(negedge clk); src_sel = 2'd1; max_cycles = 4'd8;
        pulse_start();
        repeat (20) @(negedge clk);
        max_cycles = 4'd2;
        wait_ready("R4 ready");
        check("R4 length captured at window open", int'(result), expect_val(2'd1, 4'd8));

        // R8/R6: continuous from idle without start, then repeated refresh
        @(negedge clk); start = 1'b0; src_sel = 2'd2; max_cycles = 4'd5;
        write_mode(1'b1);
        repeat (200) @(negedge clk);
        check("R8 continuous resumes from idle", int'(result), expect_val(2'd2, 4'd5));
        max_cycles = 4'd2;
        repeat (200) @(negedge clk);
        check("R6 continuous refresh", int'(result), expect_val(2'd2, 4'd2));
        check("R6 ready in continuous", int'(ready), 1);

        // R9/R1: reset while selected slow input is high
        @(negedge clk); src_sel = 2'd3; max_cycles = 4'd3;
        while (s_act != 1'b1) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ready after mid-run reset", int'(ready), 0);
        check("R1 result after mid-run reset", int'(result), 0);
        rst = 1'b0;
        wait_ready("R9 ready after reset");
        check("R9 no false opening edge", int'(result), expect_val(2'd3, 4'd3));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule